// File: doc/BRIEF.md
# Remote Alarm Indication Monitor

This block watches the timeslot-0 bytes of received frames for the far end's alarm indication and keeps a sticky alarm status flag. Each cycle it may be offered one timeslot-0 byte together with the index of the frame it came from. The alarm indication is only carried in frames with an odd index. Bytes from even frames are therefore disregarded, and in odd frames only the alarm bit is examined.

Bytes are grouped into scan windows marked by a start pulse and an end pulse. The flag is re-evaluated only when a window ends. If any odd frame in the window carried the alarm bit, the flag is set. If odd frames arrived but none carried it, the flag is cleared. If no odd frame arrived at all, the flag is left as it was. A one-cycle strobe marks every change of the flag. As a convenience for the fetch logic, the block also forms the buffer address of the timeslot-0 byte of the frame being offered, from the multiframe and frame indices.

Top module: `remote_alarm_monitor`

## Requirements
- R1: While reset is asserted (synchronous, active low) and in the first cycle after it, `alarm_flag` is 0 and `alarm_chg` is 0.
- R2: A byte offered with `frame_idx[0]` = 0 (even frame) has no effect on the flag, whatever its value.
- R3: In a byte from an odd frame only bit 5 (mask 0x20) is the alarm; all other bits have no effect.
- R4: If any odd-frame byte of a window has bit 5 set, `alarm_flag` reads 1 in the cycle after the `win_end` cycle.
- R5: If a window had at least one odd-frame byte and none had bit 5 set, `alarm_flag` reads 0 in the cycle after the `win_end` cycle.
- R6: If a window had no odd-frame byte, `alarm_flag` keeps its value and `alarm_chg` stays 0 after the window ends.
- R7: `alarm_chg` is 1 for exactly the cycles in which `alarm_flag` differs from its value one cycle earlier.
- R8: `alarm_flag` changes only in the cycle that follows a cycle with `win_end` high.
- R9: `win_start` discards everything collected so far; a byte offered in the same cycle as `win_start` (without `win_end`) belongs to the new window.
- R10: A byte offered in the same cycle as `win_end` counts for the ending window; if `win_start` is high in that cycle too, the new window starts empty.
- R11: `ts0_addr` equals `mf_idx` shifted left by 9, OR `frame_idx` shifted left by 5, with the timeslot field (bits 4..0) zero, combinationally from the inputs.
- R12: When `byte_vld` is 0 the offered byte and frame index have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_start | input | 1 | Opens a new scan window |
| win_end | input | 1 | Closes the current window and applies the update |
| byte_vld | input | 1 | A timeslot-0 byte is offered this cycle |
| ts0_byte | input | 8 | Timeslot-0 byte |
| frame_idx | input | 4 | Frame index within the multiframe of the offered byte |
| mf_idx | input | 4 | Multiframe index used for the address |
| ts0_addr | output | 13 | Buffer address of the timeslot-0 byte of the indexed frame |
| alarm_flag | output | 1 | Sticky remote alarm status |
| alarm_chg | output | 1 | One-cycle strobe on each change of the flag |

## Verification
The hardest situations to reach are the coincident pulses. These are a byte arriving in the same cycle as a window edge, and `win_start` and `win_end` high together, because they decide which window a byte belongs to. The stimulus drives long runs of windows from a bench-side shift-register generator that places start and end pulses on the same cycle as bytes, mixes even and odd frame indices, and toggles unrelated bits. It also produces windows that hold only even frames or no bytes at all, so that the hold-previous case is taken from both flag values. A bench model of the window rules predicts flag and strobe every cycle, and a separate sweep covers every multiframe and frame index for the address.

// File: rtl/rai_mon_pkg.sv
// Package: shared types for the remote alarm monitor.
// Assumes nothing beyond the widths given by the top module.
package rai_mon_pkg;
    // Per-window evidence: any odd frame seen, any alarm bit seen.
    typedef struct packed {
        logic seen;
        logic hit;
    } rai_evid_t;
endpackage

// File: rtl/rai_addr_gen.sv
// Module: rai_addr_gen
// Forms the buffer address of timeslot 0 of a frame from the
// multiframe and frame indices. Assumes the buffer is laid out as
// multiframe / frame / timeslot fields from most to least significant.
module rai_addr_gen #(
    parameter int MF_W    = 4,
    parameter int FRAME_W = 4,
    parameter int TS_W    = 5,
    localparam int ADDR_W = MF_W + FRAME_W + TS_W
) (
    input  logic [MF_W-1:0]    mf_idx,
    input  logic [FRAME_W-1:0] frame_idx,
    output logic [ADDR_W-1:0]  addr
);
    localparam logic [TS_W-1:0] TS_ZERO = '0;

    // Concatenate the fields; the timeslot is always 0.
    always_comb begin
        addr = {mf_idx, frame_idx, TS_ZERO};
    end
endmodule

// File: rtl/rai_eligibility.sv
// Module: rai_eligibility
// Decides whether an offered byte is eligible (odd frame) and whether it
// carries the alarm bit. Assumes the frame index LSB marks odd frames.
module rai_eligibility #(
    parameter int BYTE_W    = 8,
    parameter int ALARM_BIT = 5
) (
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] ts0_byte,
    input  logic              frame_lsb,
    output logic              odd_ok,
    output logic              odd_hit
);
    // Qualify by valid and odd index, then test the alarm bit.
    always_comb begin
        odd_ok  = byte_vld & frame_lsb;
        odd_hit = odd_ok & ts0_byte[ALARM_BIT];
    end
endmodule

// File: rtl/rai_window_acc.sv
// Module: rai_window_acc
// Collects per-window evidence. A byte in a start-only cycle belongs to
// the new window; a byte in an end cycle belongs to the ending window;
// start and end together leave the new window empty.
module rai_window_acc
    import rai_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      win_start,
    input  logic      win_end,
    input  logic      odd_ok,
    input  logic      odd_hit,
    output rai_evid_t evid_eff
);
    rai_evid_t evid_q;
    rai_evid_t evid_cur;

    // Evidence of this cycle's byte alone.
    always_comb begin
        evid_cur.seen = odd_ok;
        evid_cur.hit  = odd_hit;
    end

    // Evidence of the window closing now (only meaningful with win_end).
    always_comb begin
        evid_eff.seen = evid_q.seen | evid_cur.seen;
        evid_eff.hit  = evid_q.hit  | evid_cur.hit;
    end

    // Accumulate, restart on window edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evid_q <= '0;
        end else if (win_end) begin
            evid_q <= '0;
        end else if (win_start) begin
            evid_q <= evid_cur;
        end else begin
            evid_q <= evid_eff;
        end
    end
endmodule

// File: rtl/rai_flag_update.sv
// Module: rai_flag_update
// Holds the sticky alarm flag and its change strobe. Updates only on a
// window end that saw at least one odd frame.
module rai_flag_update
    import rai_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      win_end,
    input  rai_evid_t evid_eff,
    output logic      alarm_flag,
    output logic      alarm_chg
);
    logic flag_nxt;
    logic upd;

    // Next flag value: follow the hit indicator only when odd frames seen.
    always_comb begin
        upd      = win_end & evid_eff.seen;
        flag_nxt = upd ? evid_eff.hit : alarm_flag;
    end

    // Register flag and a strobe for each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
            alarm_chg  <= 1'b0;
        end else begin
            alarm_flag <= flag_nxt;
            alarm_chg  <= flag_nxt ^ alarm_flag;
        end
    end
endmodule

// File: rtl/remote_alarm_monitor.sv
// Module: remote_alarm_monitor (top)
// Watches timeslot-0 bytes of odd frames for the remote alarm bit and
// keeps a sticky flag updated once per scan window. Assumes window
// pulses and bytes are synchronous to clk; reset is synchronous, active low.
module remote_alarm_monitor
    import rai_mon_pkg::*;
#(
    parameter int MF_W      = 4,
    parameter int FRAME_W   = 4,
    parameter int TS_W      = 5,
    parameter int BYTE_W    = 8,
    parameter int ALARM_BIT = 5,
    localparam int ADDR_W   = MF_W + FRAME_W + TS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_start,
    input  logic               win_end,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  ts0_byte,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic [MF_W-1:0]    mf_idx,
    output logic [ADDR_W-1:0]  ts0_addr,
    output logic               alarm_flag,
    output logic               alarm_chg
);
    logic      odd_ok;
    logic      odd_hit;
    rai_evid_t evid_eff;

    rai_addr_gen #(
        .MF_W    (MF_W),
        .FRAME_W (FRAME_W),
        .TS_W    (TS_W)
    ) u_addr (
        .mf_idx    (mf_idx),
        .frame_idx (frame_idx),
        .addr      (ts0_addr)
    );

    rai_eligibility #(
        .BYTE_W    (BYTE_W),
        .ALARM_BIT (ALARM_BIT)
    ) u_elig (
        .byte_vld  (byte_vld),
        .ts0_byte  (ts0_byte),
        .frame_lsb (frame_idx[0]),
        .odd_ok    (odd_ok),
        .odd_hit   (odd_hit)
    );

    rai_window_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_start (win_start),
        .win_end   (win_end),
        .odd_ok    (odd_ok),
        .odd_hit   (odd_hit),
        .evid_eff  (evid_eff)
    );

    rai_flag_update u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_end    (win_end),
        .evid_eff   (evid_eff),
        .alarm_flag (alarm_flag),
        .alarm_chg  (alarm_chg)
    );
endmodule

// File: rtl/remote_alarm_monitor_chk.sv
// Module: remote_alarm_monitor_chk
// Checker bound to the top; relates ports over time.
module remote_alarm_monitor_chk #(
    parameter int MF_W      = 4,
    parameter int FRAME_W   = 4,
    parameter int TS_W      = 5,
    parameter int BYTE_W    = 8,
    parameter int ALARM_BIT = 5,
    localparam int ADDR_W   = MF_W + FRAME_W + TS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_start,
    input logic               win_end,
    input logic               byte_vld,
    input logic [BYTE_W-1:0]  ts0_byte,
    input logic [FRAME_W-1:0] frame_idx,
    input logic [MF_W-1:0]    mf_idx,
    input logic [ADDR_W-1:0]  ts0_addr,
    input logic               alarm_flag,
    input logic               alarm_chg
);
    AST_CHG_MATCHES_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_chg == (alarm_flag != $past(alarm_flag))); // R7

    AST_FLAG_HELD_OFF_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_end) |-> $stable(alarm_flag)); // R8

    AST_ODD_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && byte_vld && frame_idx[0] && ts0_byte[ALARM_BIT]) |=> alarm_flag); // R4

    AST_ADDR_TS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ts0_addr[TS_W-1:0] == '0); // R11

    AST_ADDR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ts0_addr[ADDR_W-1:TS_W] == {mf_idx, frame_idx})); // R11
endmodule

bind remote_alarm_monitor remote_alarm_monitor_chk #(
    .MF_W      (MF_W),
    .FRAME_W   (FRAME_W),
    .TS_W      (TS_W),
    .BYTE_W    (BYTE_W),
    .ALARM_BIT (ALARM_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_start  (win_start),
    .win_end    (win_end),
    .byte_vld   (byte_vld),
    .ts0_byte   (ts0_byte),
    .frame_idx  (frame_idx),
    .mf_idx     (mf_idx),
    .ts0_addr   (ts0_addr),
    .alarm_flag (alarm_flag),
    .alarm_chg  (alarm_chg)
);

// File: tb/remote_alarm_monitor_tb.sv
module remote_alarm_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_start = 1'b0;
    logic        win_end = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  ts0_byte = '0;
    logic [3:0]  frame_idx = '0;
    logic [3:0]  mf_idx = '0;
    logic [12:0] ts0_addr;
    logic        alarm_flag;
    logic        alarm_chg;

    int n_vec = 0;
    int n_bad = 0;
    logic m_seen = 1'b0, m_hit = 1'b0, m_flag = 1'b0, m_chg = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    remote_alarm_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
        .byte_vld(byte_vld), .ts0_byte(ts0_byte), .frame_idx(frame_idx),
        .mf_idx(mf_idx), .ts0_addr(ts0_addr), .alarm_flag(alarm_flag),
        .alarm_chg(alarm_chg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // One clock with the given inputs; model predicts, outputs checked after edge.
    task automatic step(input logic st, input logic en, input logic vld,
                        input logic [7:0] b, input logic [3:0] fr, input string tag);
        logic odd, hc, es, eh, nf;
        win_start = st; win_end = en; byte_vld = vld; ts0_byte = b; frame_idx = fr;
        odd = vld & fr[0];
        hc  = odd & b[5];
        es  = m_seen | odd;
        eh  = m_hit | hc;
        nf  = (en && es) ? eh : m_flag;
        m_chg  = nf ^ m_flag;
        m_flag = nf;
        if (en) begin m_seen = 1'b0; m_hit = 1'b0; end
        else if (st) begin m_seen = odd; m_hit = hc; end
        else begin m_seen = es; m_hit = eh; end
        @(posedge clk); #1;
        chk({tag, " flag"}, {31'b0, alarm_flag}, {31'b0, m_flag});
        chk({tag, " chg"},  {31'b0, alarm_chg},  {31'b0, m_chg});
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flag", {31'b0, alarm_flag}, 32'd0);
        chk("R1 reset chg",  {31'b0, alarm_chg},  32'd0);
        rst_n = 1'b1;
        step(0, 0, 0, 8'h00, 4'd0, "R1 first cycle");

        // R11: every multiframe / frame index.
        for (int m = 0; m < 16; m++) begin
            for (int f = 0; f < 16; f++) begin
                mf_idx = m[3:0]; frame_idx = f[3:0]; #1;
                chk("R11 addr", {19'b0, ts0_addr}, (m << 9) | (f << 5));
            end
        end

        // R2: even frames with alarm bit, flag stays 0.
        step(1, 0, 1, 8'hFF, 4'd2, "R2 even start");
        step(0, 1, 1, 8'h20, 4'd4, "R2 even end");
        // R4: odd hit sets.
        step(1, 0, 1, 8'h20, 4'd3, "R4 odd hit");
        step(0, 1, 0, 8'h00, 4'd0, "R4 end");
        // R3: other bits only -> clear.
        step(1, 0, 1, 8'hDF, 4'd5, "R3 other bits");
        step(0, 1, 0, 8'h00, 4'd0, "R3 R5 end");
        // R4 set again, then R6: empty and even-only windows hold 1.
        step(1, 0, 1, 8'h20, 4'd1, "R4 set");
        step(0, 1, 0, 8'h00, 4'd0, "R4 end2");
        step(1, 0, 0, 8'h20, 4'd1, "R12 vld low");
        step(0, 1, 1, 8'h00, 4'd6, "R6 even only end");
        step(1, 1, 0, 8'h00, 4'd0, "R6 empty window");
        // R12: invalid odd byte in a window ignored (hold 1).
        step(0, 0, 0, 8'h00, 4'd7, "R12 invalid odd");
        step(0, 1, 0, 8'h00, 4'd0, "R12 end");
        // R9: start discards a hit collected earlier; new window byte clear.
        step(0, 0, 1, 8'h20, 4'd9, "R9 pre hit");
        step(1, 0, 1, 8'h00, 4'd11, "R9 start byte");
        step(0, 1, 0, 8'h00, 4'd0, "R9 R5 end clears");
        // R10: byte in end cycle counts; start+end leaves new window empty.
        step(1, 1, 1, 8'h20, 4'd13, "R10 end byte");
        step(0, 1, 0, 8'h00, 4'd0, "R10 empty after");

        // Near-exhaustive pseudo-random sweep of window patterns.
        for (int i = 0; i < 20000; i++) begin
            logic [15:0] r;
            lfsr = nxt(lfsr); r = lfsr;
            lfsr = nxt(lfsr);
            step(r[0] & r[1], r[2] & r[3] & r[4], r[5] | r[6],
                 {lfsr[7:6], r[7], lfsr[4:0]}, {lfsr[11:9], r[8]},
                 "R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 sweep");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule